// File: doc/BRIEF.md
# Dual-Bank Rotation Buffer Arbiter

This block owns a 512 x 16-bit working buffer for a bit-rotation engine and decides, cycle by cycle, which of three requesters may touch it. A host port reaches the whole buffer through a 1 kB byte-address window. A fetch port fills the buffer with image data, and a packer port reads words back out for rotation. All three share one clock.

A single control input, `rot_active`, decides who owns the buffer. When it is low, the host owns the buffer and the engine ports are refused. When it is high, the host is locked out and the fetch and packer ports work together. The buffer is split into two 256-word banks, chosen by word-address bit 8. A fetch write and a packer read on different banks both complete in the same cycle. When they aim at the same bank, the fetch port wins and the packer is told to stall and hold its request.

Top module: `rotbuf_arbiter`

## Requirements
- R1: The buffer holds 512 words of 16 bits in two banks of 256 words. Word-address bit 8 selects the bank (0 = lower bank, 1 = upper bank), and every word is reachable and keeps its own value.
- R2: While `rot_active` is 0, a host request whose byte address lies in 0x01FF9000..0x01FF93FF is accepted. Address bits [9:1] give the word, bit 0 is ignored, and `host_we` = 1 means write. For an accepted read, `host_rvalid` is 1 and `host_rdata` carries the word one cycle later, with `host_err` 0.
- R3: While `rot_active` is 1, a host request is refused. A write leaves memory unchanged. A read returns `host_rvalid` = 1 with `host_rdata` = 0 one cycle later. In both cases `host_err` is 1 for one cycle, in the cycle after the request.
- R4: A host request whose address lies outside the window is refused in the same way as in R3, whatever the state of `rot_active`.
- R5: While `rot_active` is 0, the engine ports are not served. A fetch request sees `fetch_gnt` = 0 and writes nothing. A packer request sees `pack_stall` = 1 and gets no `pack_rvalid`.
- R6: While `rot_active` is 1, a fetch request is granted in the same cycle (`fetch_gnt` = 1) and writes `fetch_wdata` to word `fetch_addr`.
- R7: A packer request that is not stalled gives `pack_rvalid` = 1 and `pack_rdata` = the stored word one cycle later.
- R8: While `rot_active` is 1, a fetch request and a packer request aimed at different banks are both served in the same cycle.
- R9: While `rot_active` is 1, a fetch request and a packer request aimed at the same bank are resolved in favour of the fetch. `pack_stall` is 1, no read takes place, and `pack_rvalid` stays 0 in the next cycle.
- R10: During and right after reset, `host_rvalid`, `host_err` and `pack_rvalid` are 0. `host_rdata` and `pack_rdata` read 0 whenever their valid signal is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports |
| rst_n | input | 1 | Active-low asynchronous reset |
| rot_active | input | 1 | 1 gives the buffer to the engine ports, 0 gives it to the host |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 32 | Host byte address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, zero unless an accepted read is being returned |
| host_rvalid | output | 1 | A host read is answered this cycle |
| host_err | output | 1 | The previous host request was refused |
| fetch_req | input | 1 | Fetch write request |
| fetch_addr | input | 9 | Fetch word address |
| fetch_wdata | input | 16 | Fetch write data |
| fetch_gnt | output | 1 | Fetch write is taking place this cycle |
| pack_req | input | 1 | Packer read request |
| pack_addr | input | 9 | Packer word address |
| pack_stall | output | 1 | Packer request not served this cycle; hold it |
| pack_rdata | output | 16 | Packer read data, zero when not valid |
| pack_rvalid | output | 1 | Packer read data is valid this cycle |

## Verification
A fetch write and a packer read can land in the same cycle. The bench provokes this in two sweeps over all 512 fetch addresses. In the first sweep, the packer aims at the opposite bank (address XOR 256), and the bench predicts from the sweep order whether each word read back still holds the host pattern or already holds the fetch pattern. In the second sweep, the packer aims at the same bank (address XOR 1), and the bench expects a grant for the fetch, a stall for the packer and no packer data. A final host read of every word shows that every fetch write landed.

// File: rtl/rotbuf_pkg.sv
package rotbuf_pkg;
   // Which requester drives a bank in a given cycle
   typedef enum logic [1:0] {
      SRC_IDLE  = 2'd0,
      SRC_HOST  = 2'd1,
      SRC_FETCH = 2'd2,
      SRC_PACK  = 2'd3
   } bank_src_e;
endpackage

// File: rtl/rotbuf_bank.sv
module rotbuf_bank #(
   parameter int DATA_W = 16,
   parameter int AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              re,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata <= '0;
      else if (re) rdata <= mem[addr];
   end

   // One operation per bank per cycle (R9)
   p_one_op_r9: assert property (@(posedge clk) disable iff (!rst_n) !(we && re));
endmodule

// File: rtl/rotbuf_host_dec.sv
module rotbuf_host_dec #(
   parameter int               HADDR_W  = 32,
   parameter int               WORD_AW  = 9,
   parameter int               OFF_BITS = 1,
   parameter logic [HADDR_W-1:0] BASE   = 32'h01FF9000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_req,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic               rot_active,
   output logic               host_ok,
   output logic [WORD_AW-1:0] host_word
);
   localparam int TOP_LO = OFF_BITS + WORD_AW;
   localparam logic [HADDR_W-1:0] WIN_BYTES = HADDR_W'(1) << TOP_LO;

   logic in_win;
   logic unused_lsb;

   assign in_win     = (host_addr[HADDR_W-1:TOP_LO] == BASE[HADDR_W-1:TOP_LO]);
   assign host_word  = host_addr[TOP_LO-1:OFF_BITS];
   assign unused_lsb = ^host_addr[OFF_BITS-1:0];
   assign host_ok    = host_req && in_win && !rot_active;

   // Accepted host addresses stay inside the window (R4), and never while locked (R3)
   p_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      host_ok |-> (host_addr >= BASE) && (host_addr - BASE < WIN_BYTES));
   p_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rot_active |-> !host_ok);
endmodule

// File: rtl/rotbuf_bank_arb.sv
module rotbuf_bank_arb
   import rotbuf_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int WORD_AW   = 9,
   parameter int BANK_BITS = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rot_active,
   input  logic               host_ok,
   input  logic               host_we,
   input  logic [WORD_AW-1:0] host_word,
   input  logic [DATA_W-1:0]  host_wdata,
   input  logic               fetch_req,
   input  logic [WORD_AW-1:0] fetch_addr,
   input  logic [DATA_W-1:0]  fetch_wdata,
   input  logic               pack_req,
   input  logic [WORD_AW-1:0] pack_addr,
   output logic               fetch_gnt,
   output logic               pack_gnt,
   output logic               bank_we    [1 << BANK_BITS],
   output logic               bank_re    [1 << BANK_BITS],
   output logic [WORD_AW-BANK_BITS-1:0] bank_addr [1 << BANK_BITS],
   output logic [DATA_W-1:0]  bank_wdata [1 << BANK_BITS]
);
   localparam int NB  = 1 << BANK_BITS;
   localparam int LAW = WORD_AW - BANK_BITS;

   logic [BANK_BITS-1:0] fbank, pbank, hbank;

   assign fbank = fetch_addr[WORD_AW-1 -: BANK_BITS];
   assign pbank = pack_addr[WORD_AW-1 -: BANK_BITS];
   assign hbank = host_word[WORD_AW-1 -: BANK_BITS];

   // Fetch has fixed priority over the packer on a shared bank
   assign fetch_gnt = rot_active && fetch_req;
   assign pack_gnt  = rot_active && pack_req && !(fetch_req && (fbank == pbank));

   for (genvar i = 0; i < NB; i++) begin : g_bank
      localparam logic [BANK_BITS-1:0] ID = BANK_BITS'(i);
      bank_src_e src;

      always_comb begin
         if (fetch_gnt && fbank == ID)     src = SRC_FETCH;
         else if (pack_gnt && pbank == ID) src = SRC_PACK;
         else if (host_ok && hbank == ID)  src = SRC_HOST;
         else                              src = SRC_IDLE;
      end

      always_comb begin
         bank_we[i]    = 1'b0;
         bank_re[i]    = 1'b0;
         bank_addr[i]  = '0;
         bank_wdata[i] = '0;
         unique case (src)
            SRC_FETCH: begin
               bank_we[i]    = 1'b1;
               bank_addr[i]  = fetch_addr[LAW-1:0];
               bank_wdata[i] = fetch_wdata;
            end
            SRC_PACK: begin
               bank_re[i]   = 1'b1;
               bank_addr[i] = pack_addr[LAW-1:0];
            end
            SRC_HOST: begin
               bank_we[i]    = host_we;
               bank_re[i]    = !host_we;
               bank_addr[i]  = host_word[LAW-1:0];
               bank_wdata[i] = host_wdata;
            end
            default: ;
         endcase
      end
   end

   // Host service and engine service never coexist (R3, R5)
   p_host_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
      host_ok |-> !fetch_gnt && !pack_gnt);
   // Simultaneous engine service only on distinct banks (R8)
   p_split_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_gnt && pack_gnt) |-> (fetch_addr[WORD_AW-1 -: BANK_BITS] != pack_addr[WORD_AW-1 -: BANK_BITS]));
endmodule

// File: rtl/rotbuf_arbiter.sv
module rotbuf_arbiter #(
   parameter int          DATA_W    = 16,
   parameter int          WORD_AW   = 9,
   parameter int          BANK_BITS = 1,
   parameter int          HADDR_W   = 32,
   parameter logic [31:0] WIN_BASE  = 32'h01FF9000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rot_active,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HADDR_W-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic               host_rvalid,
   output logic               host_err,
   input  logic               fetch_req,
   input  logic [WORD_AW-1:0] fetch_addr,
   input  logic [DATA_W-1:0]  fetch_wdata,
   output logic               fetch_gnt,
   input  logic               pack_req,
   input  logic [WORD_AW-1:0] pack_addr,
   output logic               pack_stall,
   output logic [DATA_W-1:0]  pack_rdata,
   output logic               pack_rvalid
);
   localparam int NB       = 1 << BANK_BITS;
   localparam int LAW      = WORD_AW - BANK_BITS;
   localparam int OFF_BITS = $clog2(DATA_W / 8);
   localparam logic [HADDR_W-1:0] BASE = HADDR_W'(WIN_BASE);

   // Elaboration-time parameter checks
   if (DATA_W < 16 || (DATA_W % 8) != 0 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power of two of at least 16");
   end
   if (BANK_BITS < 1 || BANK_BITS >= WORD_AW) begin : g_bad_banks
      $error("BANK_BITS must be between 1 and WORD_AW-1");
   end
   if (HADDR_W <= OFF_BITS + WORD_AW) begin : g_bad_haddr
      $error("HADDR_W too narrow for the window");
   end
   if ((BASE & ((HADDR_W'(1) << (OFF_BITS + WORD_AW)) - 1)) != 0) begin : g_bad_base
      $error("WIN_BASE must be aligned to the window size");
   end

   logic               host_ok, pack_gnt;
   logic [WORD_AW-1:0] host_word;
   logic               bank_we    [NB];
   logic               bank_re    [NB];
   logic [LAW-1:0]     bank_addr  [NB];
   logic [DATA_W-1:0]  bank_wdata [NB];
   logic [DATA_W-1:0]  bank_rdata [NB];

   logic                 host_okrd_q;
   logic [BANK_BITS-1:0] host_bank_q, pack_bank_q;

   rotbuf_host_dec #(
      .HADDR_W (HADDR_W), .WORD_AW (WORD_AW), .OFF_BITS (OFF_BITS), .BASE (BASE)
   ) u_dec (
      .clk (clk), .rst_n (rst_n), .host_req (host_req), .host_addr (host_addr),
      .rot_active (rot_active), .host_ok (host_ok), .host_word (host_word)
   );

   rotbuf_bank_arb #(
      .DATA_W (DATA_W), .WORD_AW (WORD_AW), .BANK_BITS (BANK_BITS)
   ) u_arb (
      .clk (clk), .rst_n (rst_n), .rot_active (rot_active),
      .host_ok (host_ok), .host_we (host_we), .host_word (host_word), .host_wdata (host_wdata),
      .fetch_req (fetch_req), .fetch_addr (fetch_addr), .fetch_wdata (fetch_wdata),
      .pack_req (pack_req), .pack_addr (pack_addr),
      .fetch_gnt (fetch_gnt), .pack_gnt (pack_gnt),
      .bank_we (bank_we), .bank_re (bank_re), .bank_addr (bank_addr), .bank_wdata (bank_wdata)
   );

   for (genvar b = 0; b < NB; b++) begin : g_mem
      rotbuf_bank #(.DATA_W (DATA_W), .AW (LAW)) u_bank (
         .clk (clk), .rst_n (rst_n), .we (bank_we[b]), .re (bank_re[b]),
         .addr (bank_addr[b]), .wdata (bank_wdata[b]), .rdata (bank_rdata[b])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rvalid <= 1'b0;
         host_okrd_q <= 1'b0;
         host_err    <= 1'b0;
         host_bank_q <= '0;
         pack_rvalid <= 1'b0;
         pack_bank_q <= '0;
      end else begin
         host_rvalid <= host_req && !host_we;
         host_okrd_q <= host_ok && !host_we;
         host_err    <= host_req && !host_ok;
         host_bank_q <= host_word[WORD_AW-1 -: BANK_BITS];
         pack_rvalid <= pack_gnt;
         pack_bank_q <= pack_addr[WORD_AW-1 -: BANK_BITS];
      end
   end

   assign host_rdata = (host_rvalid && host_okrd_q) ? bank_rdata[host_bank_q] : '0;
   assign pack_rdata = pack_rvalid ? bank_rdata[pack_bank_q] : '0;
   assign pack_stall = pack_req && !pack_gnt;

   // Port-level timing and priority properties
   p_lock_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_active && host_req) |=> host_err);
   p_lock_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_active && host_req && !host_we) |=> (host_rvalid && host_rdata == '0));
   p_idle_engine_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !rot_active |-> (!fetch_gnt && (pack_stall == pack_req)));
   p_pack_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pack_req && !pack_stall) |=> pack_rvalid);
   p_both_served_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_active && fetch_req && pack_req &&
       fetch_addr[WORD_AW-1 -: BANK_BITS] != pack_addr[WORD_AW-1 -: BANK_BITS])
      |-> (fetch_gnt && !pack_stall));
   p_fetch_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rot_active && fetch_req && pack_req &&
       fetch_addr[WORD_AW-1 -: BANK_BITS] == pack_addr[WORD_AW-1 -: BANK_BITS])
      |-> (fetch_gnt && pack_stall));
   p_no_data_after_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pack_stall |=> !pack_rvalid);
endmodule

// File: tb/rotbuf_arbiter_tb.sv
`timescale 1ns/1ps
module rotbuf_arbiter_tb;
   localparam logic [31:0] BASE = 32'h01FF9000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rot_active = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [31:0] host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic [15:0] host_rdata;
   logic        host_rvalid, host_err;
   logic        fetch_req = 1'b0;
   logic [8:0]  fetch_addr = '0;
   logic [15:0] fetch_wdata = '0;
   logic        fetch_gnt;
   logic        pack_req = 1'b0;
   logic [8:0]  pack_addr = '0;
   logic        pack_stall;
   logic [15:0] pack_rdata;
   logic        pack_rvalid;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rotbuf_arbiter u_dut (
      .clk (clk), .rst_n (rst_n), .rot_active (rot_active),
      .host_req (host_req), .host_we (host_we), .host_addr (host_addr),
      .host_wdata (host_wdata), .host_rdata (host_rdata), .host_rvalid (host_rvalid),
      .host_err (host_err),
      .fetch_req (fetch_req), .fetch_addr (fetch_addr), .fetch_wdata (fetch_wdata),
      .fetch_gnt (fetch_gnt),
      .pack_req (pack_req), .pack_addr (pack_addr), .pack_stall (pack_stall),
      .pack_rdata (pack_rdata), .pack_rvalid (pack_rvalid)
   );

   function automatic logic [15:0] pat_host(int w);
      logic [31:0] t;
      t = w * 32'h9E37;
      return t[15:0] ^ 16'h5A5A;
   endfunction
   function automatic logic [15:0] pat_fetch(int w);
      logic [31:0] t;
      t = w * 3 + 32'h1234;
      return t[15:0];
   endfunction
   function automatic logic [15:0] pat_conf(int w);
      logic [31:0] t;
      t = w * 7;
      return t[15:0] ^ 16'hC000;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One host access; checks the registered response in the following cycle
   task automatic host_op(input string tag, input logic we, input logic [31:0] addr,
                          input logic [15:0] wd, input logic [15:0] exp_rd,
                          input logic exp_err);
      @(negedge clk);
      host_req = 1'b1; host_we = we; host_addr = addr; host_wdata = wd;
      @(negedge clk);
      host_req = 1'b0; host_we = 1'b0;
      #1;
      chk({tag, " rvalid"}, host_rvalid, !we);
      chk({tag, " err"}, host_err, exp_err);
      if (!we) chk({tag, " rdata"}, host_rdata, exp_rd);
   endtask

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      chk("R10 host_rvalid in reset", host_rvalid, 0);
      chk("R10 host_err in reset", host_err, 0);
      chk("R10 pack_rvalid in reset", pack_rvalid, 0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R10 host_rdata after reset", host_rdata, 0);
      chk("R10 pack_rdata after reset", pack_rdata, 0);

      // R1/R2: host fills every word (odd byte address for odd words), then reads back
      for (int w = 0; w < 512; w++)
         host_op("R2 host write", 1'b1, BASE + 32'(2 * w) + 32'(w & 1), pat_host(w), '0, 1'b0);
      for (int w = 0; w < 512; w++)
         host_op(w < 256 ? "R2 host read lower bank" : "R1 host read upper bank",
                 1'b0, BASE + 32'(2 * w), '0, pat_host(w), 1'b0);

      // R4: outside the window
      host_op("R4 write above window", 1'b1, BASE + 32'h400, 16'hFFFF, '0, 1'b1);
      host_op("R4 write below window", 1'b1, BASE - 32'h2, 16'hFFFF, '0, 1'b1);
      host_op("R4 read above window", 1'b0, BASE + 32'h400, '0, 16'h0000, 1'b1);
      host_op("R4 word 0 unchanged", 1'b0, BASE, '0, pat_host(0), 1'b0);
      host_op("R4 word 511 unchanged", 1'b0, BASE + 32'h3FE, '0, pat_host(511), 1'b0);

      // R5: engine ports refused while the host owns the buffer
      @(negedge clk);
      fetch_req = 1'b1; fetch_addr = 9'd5; fetch_wdata = 16'h0000;
      pack_req = 1'b1; pack_addr = 9'd300;
      #1;
      chk("R5 fetch_gnt low", fetch_gnt, 0);
      chk("R5 pack_stall high", pack_stall, 1);
      @(negedge clk);
      fetch_req = 1'b0; pack_req = 1'b0;
      #1;
      chk("R5 no pack_rvalid", pack_rvalid, 0);
      host_op("R5 word 5 unchanged", 1'b0, BASE + 32'd10, '0, pat_host(5), 1'b0);

      // R3: host locked out while rotating
      rot_active = 1'b1;
      host_op("R3 locked write", 1'b1, BASE + 32'd14, 16'hDEAD, '0, 1'b1);
      host_op("R3 locked read", 1'b0, BASE + 32'd14, '0, 16'h0000, 1'b1);
      @(negedge clk); #1;
      chk("R3 err is a single pulse", host_err, 0);
      rot_active = 1'b0;
      host_op("R3 word 7 unchanged", 1'b0, BASE + 32'd14, '0, pat_host(7), 1'b0);

      // R6/R7/R8: fetch and packer on opposite banks every cycle
      rot_active = 1'b1;
      for (int a = 0; a < 512; a++) begin
         @(negedge clk);
         if (a > 0) begin
            int p;
            p = (a - 1) ^ 256;
            chk("R7 pack_rvalid", pack_rvalid, 1);
            chk("R8 pack_rdata split banks", pack_rdata,
                (a - 1) < 256 ? pat_host(p) : pat_fetch(p));
         end
         fetch_req = 1'b1; fetch_addr = 9'(a); fetch_wdata = pat_fetch(a);
         pack_req = 1'b1; pack_addr = 9'(a ^ 256);
         #1;
         chk("R6 fetch_gnt", fetch_gnt, 1);
         chk("R8 pack not stalled", pack_stall, 0);
      end
      @(negedge clk);
      fetch_req = 1'b0; pack_req = 1'b0;
      #1;
      chk("R7 last pack_rvalid", pack_rvalid, 1);
      chk("R8 last pack_rdata", pack_rdata, pat_fetch(511 ^ 256));

      // R9: same-bank collisions, fetch wins
      for (int a = 0; a < 512; a++) begin
         @(negedge clk);
         if (a > 0) begin
            chk("R9 no pack_rvalid after stall", pack_rvalid, 0);
            chk("R10 pack_rdata zero when invalid", pack_rdata, 0);
         end
         fetch_req = 1'b1; fetch_addr = 9'(a); fetch_wdata = pat_conf(a);
         pack_req = 1'b1; pack_addr = 9'(a ^ 1);
         #1;
         chk("R9 fetch granted", fetch_gnt, 1);
         chk("R9 pack stalled", pack_stall, 1);
      end
      @(negedge clk);
      fetch_req = 1'b0;
      pack_addr = 9'd3;
      #1;
      chk("R9 last stall gave no data", pack_rvalid, 0);
      chk("R7 held request released", pack_stall, 0);
      @(negedge clk);
      pack_req = 1'b0;
      #1;
      chk("R7 released pack_rvalid", pack_rvalid, 1);
      chk("R7 released pack_rdata", pack_rdata, pat_conf(3));

      // R6: every fetch write landed
      rot_active = 1'b0;
      for (int w = 0; w < 512; w++)
         host_op("R6 fetch data visible to host", 1'b0, BASE + 32'(2 * w), '0, pat_conf(w), 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL R10 watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule